// File: doc/BRIEF.md
# Conversion Pacer and Trigger Selector

This block produces one-cycle start-of-conversion strobes for an analog-to-digital converter. It runs on a 10 MHz crystal clock. Its timebase is either that clock or a 1 MHz rate made by a divide-by-ten clock enable. The timebase drives two cascaded 16-bit dividers, so the pacer rate is the timebase divided by the product of the two divisors.

Software uses a small register write port to set both divisors, the timebase, the trigger source and gating. The trigger source can be the internal pacer, a software strobe that starts exactly one conversion, or a rising edge on an external trigger pin. When gating is enabled, an external gate input holds off paced conversions while it is low. Both external inputs pass through two-flop synchronizers.

Register map (write only, `wr_addr`): 0 sets divisor A, 1 sets divisor B, 2 sets control, and 3 issues the software strobe (its data is ignored). The control fields are: bits [1:0] select the source (0 = none, 1 = pacer, 2 = software, 3 = external); bit 2 set selects the 1 MHz timebase; bit 3 set enables gating.

Top module: `conv_pacer`

## Requirements
- R1: After reset `conv_start` is low, the source is none, and both divisors hold 2.
- R2: With the pacer selected on the 10 MHz timebase, the first strobe comes A·B cycles after the control write takes effect, and later strobes repeat every A·B cycles.
- R3: With bit 2 set, the first strobe and the spacing between strobes are both 10·A·B cycles.
- R4: A divisor value of 0 or 1 behaves exactly like 2.
- R5: With the software source selected, a write to address 3 produces exactly one strobe in the cycle after the write. In any other mode the same write produces no strobe.
- R6: With the external source selected, a rising edge on `ext_trig` produces one strobe 3 cycles after the edge. Holding the pin high gives no further strobes, and in other modes the pin is ignored.
- R7: With the pacer selected and bit 3 set, no strobe is issued while the synchronized `ext_gate` is low. Strobes resume once it is high.
- R8: Every write to the control register clears the prescaler and both dividers. The pacer phase therefore restarts from that write.
- R9: With source none selected, `conv_start` stays low.
- R10: In pacer mode each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| ext_trig | input | 1 | External trigger pin (asynchronous) |
| ext_gate | input | 1 | External gate pin (asynchronous) |
| conv_start | output | 1 | Single-cycle start-of-conversion strobe |

## Verification
Each result falls due at a fixed number of cycles after its stimulus:
- A software strobe is visible on the first falling edge after the write's clock edge.
- An external edge appears on the third rising edge after the pin changes.
- A pacer strobe appears exactly A·B cycles (or 10·A·B cycles on the slow timebase) after the control write, with the same spacing afterwards.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from each stimulus and compares the count with the value computed by its own period function. For ignored stimuli, it watches the output over a window at least as long as any due latency.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int DIV_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int PRESCALE = 10;

    localparam logic [ADDR_W-1:0] ADR_DIV_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_SOFT  = 2'd3;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_EXT   = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0] div_a;
        logic [DIV_W-1:0] div_b;
        src_sel_e         src;
        logic             slow;
        logic             gate_en;
        logic             trig_prev;
        logic             start;
    } ctl_state_t;
endpackage

// File: rtl/pacer_prescale.sv
module pacer_prescale #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !slow_i || (cnt_q == LAST);
        if (clr_i || !slow_i || cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // On the slow timebase two ticks are never adjacent.
    assert_slow_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_i && tick_o && !clr_i) |=> (!tick_o || !slow_i));
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] div_i,
    output logic         pulse_o
);
    logic [W-1:0] count_d, count_q;
    logic [W-1:0] div_eff;
    logic         wrap;

    always_comb begin
        div_eff = (div_i < W'(2)) ? W'(2) : div_i;
        wrap    = count_q >= (div_eff - W'(1));
        pulse_o = en_i && wrap && !clr_i;
        count_d = count_q;
        if (clr_i)
            count_d = '0;
        else if (en_i && wrap)
            count_d = '0;
        else if (en_i)
            count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_q == '0));
endmodule

// File: rtl/pacer_sync.sv
module pacer_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    logic [N-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
        lvl_o  = stab_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end
endmodule

// File: rtl/conv_pacer.sv
module conv_pacer
    import pacer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    input  logic              ext_trig,
    input  logic              ext_gate,
    output logic              conv_start
);
    ctl_state_t st_d, st_q;
    logic       clr, sw_hit, tick, pulse_a, pace_pulse;
    logic       trig_lvl, gate_lvl, trig_rise, gate_ok;
    logic [1:0] sync_lvl;

    pacer_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ext_gate, ext_trig}),
        .lvl_o(sync_lvl)
    );

    pacer_prescale #(.RATIO(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .slow_i(st_q.slow), .tick_o(tick)
    );

    pacer_divider #(.W(DIV_W)) u_div_a (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(tick),
        .div_i(st_q.div_a), .pulse_o(pulse_a)
    );

    pacer_divider #(.W(DIV_W)) u_div_b (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(pulse_a),
        .div_i(st_q.div_b), .pulse_o(pace_pulse)
    );

    always_comb begin
        trig_lvl  = sync_lvl[0];
        gate_lvl  = sync_lvl[1];
        trig_rise = trig_lvl && !st_q.trig_prev;
        gate_ok   = !st_q.gate_en || gate_lvl;

        st_d           = st_q;
        st_d.trig_prev = trig_lvl;
        clr            = 1'b0;
        sw_hit         = 1'b0;

        if (wr_en) begin
            case (wr_addr)
                ADR_DIV_A: st_d.div_a = wr_data;
                ADR_DIV_B: st_d.div_b = wr_data;
                ADR_CTRL: begin
                    st_d.src     = src_sel_e'(wr_data[1:0]);
                    st_d.slow    = wr_data[2];
                    st_d.gate_en = wr_data[3];
                    clr          = 1'b1;
                end
                default:   sw_hit = 1'b1;
            endcase
        end

        case (st_q.src)
            SRC_PACER: st_d.start = pace_pulse && gate_ok;
            SRC_SOFT:  st_d.start = sw_hit;
            SRC_EXT:   st_d.start = trig_rise;
            default:   st_d.start = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div_a     <= DIV_W'(2);
            st_q.div_b     <= DIV_W'(2);
            st_q.src       <= SRC_NONE;
            st_q.slow      <= 1'b0;
            st_q.gate_en   <= 1'b0;
            st_q.trig_prev <= 1'b0;
            st_q.start     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_start = st_q.start;

    assert_none_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.src == SRC_NONE) |=> !conv_start);

    assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.src == SRC_PACER && st_q.gate_en && !gate_lvl) |=> !conv_start);

    assert_pacer_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && st_q.src == SRC_PACER) |=> !conv_start);

    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);
endmodule

// File: tb/conv_pacer_test.sv
module conv_pacer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_trig = 1'b0;
    logic        ext_gate = 1'b0;
    logic        conv_start;

    int n_checks = 0;
    int n_fails  = 0;

    conv_pacer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_trig(ext_trig), .ext_gate(ext_gate),
        .conv_start(conv_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_div(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic int exp_period(input int a, input int b, input bit slow);
        return (slow ? 10 : 1) * eff_div(a) * eff_div(b);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts falling edges until conv_start is seen high (returns limit if never).
    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        while (!conv_start && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_pulses(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) c++;
        end
    endtask

    task automatic pacer_case(input int a, input int b, input bit slow, input string tag);
        int n, exp;
        exp = exp_period(a, b, slow);
        reg_write(2'd0, 16'(a));
        reg_write(2'd1, 16'(b));
        reg_write(2'd2, {13'd0, slow, 2'd1});
        wait_pulse(exp + 50, n);
        check(n == exp, {tag, " first strobe"}, n, exp);
        @(negedge clk);
        check(conv_start == 1'b0, "R10 strobe width", int'(conv_start), 0);
        wait_pulse(exp + 50, n);
        check(n + 1 == exp, {tag, " period"}, n + 1, exp);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int n, c, seed_init;
        seed_init = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check(conv_start == 1'b0, "R1 reset output", int'(conv_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(conv_start == 1'b0, "R1 after reset", int'(conv_start), 0);

        // R1 default divisors of 2: pacer period 4 without divisor writes
        reg_write(2'd2, 16'h0001);
        wait_pulse(100, n);
        check(n == 4, "R1 default divisors", n, 4);

        // R9 source none
        reg_write(2'd2, 16'h0000);
        count_pulses(200, c);
        check(c == 0, "R9 none stays low", c, 0);

        // R2 directed
        pacer_case(3, 5, 1'b0, "R2 fast 3x5");
        pacer_case(2, 2, 1'b0, "R2 fast min");
        // R3 directed
        pacer_case(4, 3, 1'b1, "R3 slow 4x3");
        // R4 clamp
        pacer_case(0, 1, 1'b0, "R4 clamp 0x1");
        pacer_case(1, 7, 1'b1, "R4 clamp slow 1x7");

        // R8 restart: control write mid-period restarts phase
        reg_write(2'd0, 16'd20);
        reg_write(2'd1, 16'd10);
        reg_write(2'd2, 16'h0001);
        repeat (77) @(negedge clk);
        reg_write(2'd2, 16'h0001);
        wait_pulse(400, n);
        check(n == 200, "R8 restart phase", n, 200);

        // Random pacer settings
        for (int k = 0; k < 10; k++) begin
            int a, b;
            bit s;
            a = $urandom_range(0, 12);
            b = $urandom_range(0, 12);
            s = 1'($urandom_range(0, 1));
            pacer_case(a, b, s, s ? "R3 random slow" : "R2 random fast");
        end

        // R6 external ignored in pacer mode (long period)
        reg_write(2'd0, 16'd1000);
        reg_write(2'd1, 16'd1000);
        reg_write(2'd2, 16'h0001);
        ext_trig = 1'b1;
        count_pulses(10, c);
        check(c == 0, "R6 ext ignored in pacer", c, 0);
        ext_trig = 1'b0;
        // R5 soft ignored in pacer mode
        reg_write(2'd3, 16'h0);
        check(conv_start == 1'b0, "R5 soft ignored in pacer", int'(conv_start), 0);

        // R5 software mode
        reg_write(2'd2, 16'h0002);
        repeat (3) @(negedge clk);
        reg_write(2'd3, 16'hBEEF);
        check(conv_start == 1'b1, "R5 soft strobe", int'(conv_start), 1);
        count_pulses(20, c);
        check(c == 0, "R5 soft exactly one", c, 0);

        // R6 external mode
        reg_write(2'd2, 16'h0003);
        repeat (4) @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk); @(negedge clk);
        check(conv_start == 1'b0, "R6 not early", int'(conv_start), 0);
        @(negedge clk);
        check(conv_start == 1'b1, "R6 edge latency 3", int'(conv_start), 1);
        count_pulses(20, c);
        check(c == 0, "R6 held high one strobe", c, 0);
        ext_trig = 1'b0;
        repeat (5) @(negedge clk);
        ext_trig = 1'b1;
        count_pulses(6, c);
        check(c == 1, "R6 second edge", c, 1);
        ext_trig = 1'b0;
        // R5 soft ignored in external mode
        reg_write(2'd3, 16'h1);
        count_pulses(5, c);
        check(c == 0 && conv_start == 1'b0, "R5 soft ignored in ext", c, 0);

        // R7 gating
        ext_gate = 1'b0;
        reg_write(2'd0, 16'd2);
        reg_write(2'd1, 16'd2);
        reg_write(2'd2, 16'h0009);
        count_pulses(100, c);
        check(c == 0, "R7 gate low holds off", c, 0);
        ext_gate = 1'b1;
        count_pulses(100, c);
        check(c >= 23 && c <= 25, "R7 gate high resumes", c, 24);
        ext_gate = 1'b0;
        repeat (3) @(negedge clk);
        count_pulses(60, c);
        check(c == 0, "R7 gate low again", c, 0);
        // gate ignored when bit 3 clear
        reg_write(2'd2, 16'h0001);
        count_pulses(40, c);
        check(c == 10, "R7 gate disabled", c, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule